// File: doc/BRIEF.md
# Programmable Clock Divider with Duty-Cycle Correction

This block divides an incoming clock by a whole ratio of N+M+2, where N and M are two 4-bit programmable fields. Without correction the divided clock is high for N+1 input cycles and low for M+1, so a designer can set any duty cycle the ratio allows. With correction enabled and the fields set as M = N (even ratio) or M = N+1 (odd ratio), the output approaches 50%. For an odd ratio the falling edge of the output is moved onto the falling edge of the input clock, half an input cycle after the last full high cycle.

A bypass mode passes the input clock unchanged to the output. Settings are taken up only at the boundary between two output periods, so a change never shortens a pulse in flight. A sync input forces a new period to begin at once, and a fault flag reports a correction request whose field relation cannot be corrected. In that case the divider falls back to plain timing. Reset is synchronous and active high.

Top module: `clkdiv_dcc`

## Requirements
- R1: With the correction-disable input high, the output period is N+M+2 input cycles: high for N+1 input cycles, starting on a rising input edge, and low for M+1.
- R2: With correction enabled (disable input low) and M = N, the output is high for N+1 and low for N+1 input cycles, whatever the input duty cycle.
- R3: With correction enabled and M = N+1, the output is high for N+1 input cycles plus the high phase of one input cycle, so it falls on a falling input edge. It is then low for the rest of the 2N+3 input cycles.
- R4: With correction enabled, bypass off and M equal to neither N nor N+1, config_error reads 1 and the timing follows R1. In every other setting config_error reads 0. The flag follows the settings that are in use.
- R5: With bypass high, the output equals the input clock, including its duty cycle. N, M and the correction input then have no effect, and config_error reads 0.
- R6: N, M, bypass and correction values take effect only at the rising input edge that starts the next output period. A change made during a period leaves that period's high and low times unchanged.
- R7: A rising input edge that samples sync high starts a new output period at once: the output goes high at that edge, and the current input settings are taken up.
- R8: While reset is high at a rising edge, the output is low and config_error is 0. The first rising edge after reset is released starts a high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Restart the output period at this rising edge |
| n_cfg | input | 4 | High-stretch field N (high for N+1 cycles) |
| m_cfg | input | 4 | Low-stretch field M (low for M+1 cycles) |
| bypass | input | 1 | Pass the input clock straight to the output |
| dcc_dis | input | 1 | 1 disables duty correction, 0 enables it |
| clk_out | output | 1 | Divided or bypassed clock |
| config_error | output | 1 | Correction requested with an uncorrectable N/M relation |

## Verification
The bench times every high and low stretch of the output in real time at input duty cycles of 20%, 30%, 50%, 70% and 80%. An odd-ratio correction that placed its edge on a rising input edge would be off by a half cycle that depends on the duty cycle, and this measurement catches it. Every N/M pair is swept with correction off and on. This exposes an off-by-one in the high or low count, a missing fallback on uncorrectable pairs, and a wrong fault flag. Directed tests then change the settings in the middle of a period and pulse sync in the middle of a long low phase. A divider that took settings up at once would distort the current pulse. One that ignored sync would stay low past the restart edge.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    localparam int FIELD_W = 4;
    localparam int CNT_W   = FIELD_W + 1;

    typedef struct packed {
        logic [FIELD_W-1:0] n;
        logic [FIELD_W-1:0] m;
        logic               bypass;
        logic               dcc_en;
    } div_cfg_t;

    typedef enum logic [1:0] {
        MODE_PLAIN    = 2'd0,
        MODE_EVEN_DCC = 2'd1,
        MODE_ODD_DCC  = 2'd2,
        MODE_BYPASS   = 2'd3
    } div_mode_t;

    // Correction requested but the field relation is not correctable.
    function automatic logic dcc_fault(input div_cfg_t c);
        logic [CNT_W-1:0] n_ext;
        logic [CNT_W-1:0] m_ext;
        n_ext = {1'b0, c.n};
        m_ext = {1'b0, c.m};
        return c.dcc_en && !c.bypass && (m_ext != n_ext) && (m_ext != n_ext + 1'b1);
    endfunction

    function automatic div_mode_t classify(input div_cfg_t c);
        if (c.bypass)
            return MODE_BYPASS;
        if (!c.dcc_en || dcc_fault(c))
            return MODE_PLAIN;
        if (c.m == c.n)
            return MODE_EVEN_DCC;
        return MODE_ODD_DCC;
    endfunction

    // Index of the last input cycle of an output period.
    function automatic logic [CNT_W-1:0] last_count(input div_cfg_t c);
        return {1'b0, c.n} + {1'b0, c.m} + 1'b1;
    endfunction

endpackage

// File: rtl/clkdiv_cfg_latch.sv
`timescale 1ns/1ps
module clkdiv_cfg_latch
    import clkdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  div_cfg_t  cfg_in,
    output div_cfg_t  cfg_act,
    output div_mode_t mode_act,
    output logic      err_act
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act  <= '0;
            mode_act <= MODE_PLAIN;
            err_act  <= 1'b0;
        end else if (load) begin
            cfg_act  <= cfg_in;
            mode_act <= classify(cfg_in);
            err_act  <= dcc_fault(cfg_in);
        end
    end

    // Settings in use may only move at a period boundary.
    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_act));

endmodule

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
module clkdiv_counter
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync,
    input  div_cfg_t         cfg_act,
    input  div_mode_t        mode_act,
    output logic             load,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic             div_hi
);

    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        last    = last_count(cfg_act);
        cnt_inc = cnt + 1'b1;
        load    = !running || sync || (mode_act == MODE_BYPASS) || (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
            div_hi  <= 1'b0;
        end else if (load) begin
            running <= 1'b1;
            cnt     <= '0;
            div_hi  <= 1'b1;
        end else begin
            cnt     <= cnt_inc;
            div_hi  <= (cnt_inc <= {1'b0, cfg_act.n});
        end
    end

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_count(cfg_act));

endmodule

// File: rtl/clkdiv_halfedge.sv
`timescale 1ns/1ps
module clkdiv_halfedge
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             running,
    input  div_mode_t        mode_act,
    input  div_cfg_t         cfg_act,
    input  logic [CNT_W-1:0] cnt,
    output logic             ext_hi
);

    // Captured on the falling edge inside the last full high cycle, held
    // to the next falling edge: stretches the high phase by half a cycle.
    always_ff @(negedge clk) begin
        if (rst)
            ext_hi <= 1'b0;
        else
            ext_hi <= running && (mode_act == MODE_ODD_DCC) && (cnt == {1'b0, cfg_act.n});
    end

endmodule

// File: rtl/clkdiv_dcc.sv
`timescale 1ns/1ps
module clkdiv_dcc
    import clkdiv_pkg::*;
(
    input  logic               clk_in,
    input  logic               rst,
    input  logic               sync,
    input  logic [FIELD_W-1:0] n_cfg,
    input  logic [FIELD_W-1:0] m_cfg,
    input  logic               bypass,
    input  logic               dcc_dis,
    output logic               clk_out,
    output logic               config_error
);

    div_cfg_t         cfg_in;
    div_cfg_t         cfg_act;
    div_mode_t        mode_act;
    logic             load;
    logic             running;
    logic [CNT_W-1:0] cnt;
    logic             div_hi;
    logic             ext_hi;

    always_comb begin
        cfg_in.n      = n_cfg;
        cfg_in.m      = m_cfg;
        cfg_in.bypass = bypass;
        cfg_in.dcc_en = !dcc_dis;
    end

    clkdiv_cfg_latch u_cfg (
        .clk      (clk_in),
        .rst      (rst),
        .load     (load),
        .cfg_in   (cfg_in),
        .cfg_act  (cfg_act),
        .mode_act (mode_act),
        .err_act  (config_error)
    );

    clkdiv_counter u_cnt (
        .clk      (clk_in),
        .rst      (rst),
        .sync     (sync),
        .cfg_act  (cfg_act),
        .mode_act (mode_act),
        .load     (load),
        .running  (running),
        .cnt      (cnt),
        .div_hi   (div_hi)
    );

    clkdiv_halfedge u_half (
        .clk      (clk_in),
        .rst      (rst),
        .running  (running),
        .mode_act (mode_act),
        .cfg_act  (cfg_act),
        .cnt      (cnt),
        .ext_hi   (ext_hi)
    );

    // Both sources overlap at every handover, so the OR never dips.
    assign clk_out = (mode_act == MODE_BYPASS) ? clk_in : (div_hi | ext_hi);

    assert_no_stretch_on_fault_R4: assert property (@(posedge clk_in) disable iff (rst)
        config_error |-> !ext_hi);

    assert_sync_restart_R7: assert property (@(posedge clk_in) disable iff (rst)
        sync |=> div_hi);

endmodule

// File: tb/tb_clkdiv_dcc.sv
`timescale 1ns/1ps
module tb_clkdiv_dcc;

    localparam real PERIOD = 5.0;
    localparam real TOL    = 0.01;

    typedef struct packed {
        logic [3:0]  n;
        logic [3:0]  m;
        logic        byp;
        logic        dis;
        logic [15:0] hi_ps;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{4'd3,  4'd3,  1'b0, 1'b1, 16'd2500},
        '{4'd2,  4'd5,  1'b0, 1'b1, 16'd1500},
        '{4'd0,  4'd0,  1'b0, 1'b1, 16'd2500},
        '{4'd4,  4'd4,  1'b0, 1'b0, 16'd1500},
        '{4'd4,  4'd4,  1'b0, 1'b0, 16'd3500},
        '{4'd2,  4'd3,  1'b0, 1'b0, 16'd1500},
        '{4'd2,  4'd3,  1'b0, 1'b0, 16'd3500},
        '{4'd0,  4'd1,  1'b0, 1'b0, 16'd2500},
        '{4'd14, 4'd15, 1'b0, 1'b0, 16'd4000},
        '{4'd15, 4'd15, 1'b0, 1'b0, 16'd1000},
        '{4'd1,  4'd6,  1'b0, 1'b0, 16'd2500},
        '{4'd5,  4'd5,  1'b1, 1'b0, 16'd1500},
        '{4'd5,  4'd9,  1'b1, 1'b1, 16'd3500}
    };

    logic       clk_in = 1'b0;
    logic       rst    = 1'b1;
    logic       sync   = 1'b0;
    logic [3:0] n_cfg  = 4'd0;
    logic [3:0] m_cfg  = 4'd0;
    logic       bypass = 1'b0;
    logic       dcc_dis = 1'b1;
    logic       clk_out;
    logic       config_error;

    real hi_ns = 2.5;
    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    clkdiv_dcc dut (
        .clk_in       (clk_in),
        .rst          (rst),
        .sync         (sync),
        .n_cfg        (n_cfg),
        .m_cfg        (m_cfg),
        .bypass       (bypass),
        .dcc_dis      (dcc_dis),
        .clk_out      (clk_out),
        .config_error (config_error)
    );

    initial begin
        forever begin
            #(PERIOD - hi_ns);
            clk_in = 1'b1;
            #(hi_ns);
            clk_in = 1'b0;
        end
    end

    task automatic check_real(input string tag, input string what, input real act, input real exp);
        checks++;
        if ((act - exp > TOL) || (exp - act > TOL)) begin
            errors++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", tag, what, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int n, input int m, input bit byp, input bit dis);
        if (byp)                     return "R5";
        if (dis)                     return "R1";
        if (m == n)                  return "R2";
        if (m == n + 1)              return "R3";
        return "R4";
    endfunction

    function automatic real exp_hi(input int n, input int m, input bit byp, input bit dis, input real x);
        real h;
        if (byp) return x;
        h = (n + 1) * PERIOD;
        if (!dis && (m == n + 1)) h = h + x;
        return h;
    endfunction

    function automatic real exp_lo(input int n, input int m, input bit byp, input bit dis, input real x);
        if (byp) return PERIOD - x;
        return (n + m + 2) * PERIOD - exp_hi(n, m, byp, dis, x);
    endfunction

    task automatic set_duty(input real h);
        @(negedge clk_in);
        #0.1;
        hi_ns = h;
    endtask

    task automatic apply_sync(input int n, input int m, input bit byp, input bit dis);
        @(posedge clk_in);
        #1;
        n_cfg = 4'(n); m_cfg = 4'(m); bypass = byp; dcc_dis = dis;
        sync = 1'b1;
        @(posedge clk_in);
        #1;
        sync = 1'b0;
    endtask

    task automatic run_case(input int n, input int m, input bit byp, input bit dis);
        real t0, t1, t2;
        string tag;
        tag = tag_of(n, m, byp, dis);
        apply_sync(n, m, byp, dis);
        @(posedge clk_out); t0 = $realtime;
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        #1;
        check_real(tag, $sformatf("high n=%0d m=%0d byp=%0d dis=%0d", n, m, byp, dis),
                   t1 - t0, exp_hi(n, m, byp, dis, hi_ns));
        check_real(tag, $sformatf("low n=%0d m=%0d byp=%0d dis=%0d", n, m, byp, dis),
                   t2 - t1, exp_lo(n, m, byp, dis, hi_ns));
        // R4 flag: set only for correction with an uncorrectable relation
        check_bit("R4", $sformatf("config_error n=%0d m=%0d byp=%0d dis=%0d", n, m, byp, dis),
                  config_error, !byp && !dis && (m != n) && (m != n + 1));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_in);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        real t0, t1, t2;
        // R8: reset holds output low and flag clear, even with a faulty setting
        n_cfg = 4'd2; m_cfg = 4'd7; bypass = 1'b0; dcc_dis = 1'b0;
        repeat (4) @(posedge clk_in);
        #1;
        check_bit("R8", "clk_out in reset", clk_out, 1'b0);
        check_bit("R8", "config_error in reset", config_error, 1'b0);
        rst = 1'b0;
        #1;
        check_bit("R8", "clk_out before first edge", clk_out, 1'b0);
        @(posedge clk_in);
        #1;
        check_bit("R8", "clk_out after first edge", clk_out, 1'b1);
        check_bit("R4", "config_error after load", config_error, 1'b1);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            set_duty(real'(VECS[i].hi_ps) / 1000.0);
            run_case(int'(VECS[i].n), int'(VECS[i].m), VECS[i].byp, VECS[i].dis);
        end

        // Sweep of every N/M pair, correction off then on, 70% input duty
        set_duty(3.5);
        for (int d = 1; d >= 0; d--)
            for (int n = 0; n < 16; n++)
                for (int m = 0; m < 16; m++)
                    run_case(n, m, 1'b0, d[0]);

        // R6: change mid-period without sync; current period keeps old timing
        set_duty(2.5);
        apply_sync(3, 3, 1'b0, 1'b1);
        @(posedge clk_out);
        #1;
        n_cfg = 4'd1; m_cfg = 4'd5;
        t0 = $realtime - 1.0;
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        check_real("R6", "high of running period", t1 - t0, 4 * PERIOD);
        check_real("R6", "low of running period", t2 - t1, 4 * PERIOD);
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t0 = $realtime;
        check_real("R6", "high of next period", t1 - t2, 2 * PERIOD);
        check_real("R6", "low of next period", t0 - t1, 6 * PERIOD);

        // R7: sync in the middle of a long low phase restarts at once
        apply_sync(0, 15, 1'b0, 1'b1);
        @(negedge clk_out);
        repeat (3) @(posedge clk_in);
        #1;
        check_bit("R7", "clk_out low before sync", clk_out, 1'b0);
        sync = 1'b1;
        @(posedge clk_in);
        #1;
        sync = 1'b0;
        check_bit("R7", "clk_out high at sync edge", clk_out, 1'b1);
        @(posedge clk_in);
        #1;
        check_bit("R7", "clk_out low after one cycle", clk_out, 1'b0);

        // R5: bypass ignores N, M and correction, flag stays clear
        set_duty(1.0);
        run_case(2, 9, 1'b1, 1'b0);

        finish_run();
    end

endmodule